// File: doc/BRIEF.md
# ADC Result and Control Register Bank

This block is the register side of a 10-bit, eight-channel successive-approximation converter. The block receives a one-cycle result strobe with a 10-bit value and a channel number. It stores the value left-justified in one of four 16-bit result registers and raises a completion flag. Software reaches the block over an 8-bit bus. The bus can read the result registers and can read and write one control/status byte. The fields of that byte drive the converter as the start, scan, clock-select and channel-select controls.

A 16-bit result cannot be read in one bus access. A read of a result's upper byte therefore copies that result's lower byte into a shared holding latch. The next lower-byte read returns the latch, so the two halves always belong to the same conversion. The completion flag is protected against blind clears: a write of 0 clears it only after software has read it as 1.

All state clears on the synchronous active-low reset. It also clears in any cycle where the low-power stop input is high.

Top module: `adc_regbank`

## Requirements
- R1: A strobed value v[9:0] is stored as register bits 15:8 = v[9:2] and 7:6 = v[1:0]. Register bits 5:0 always read as 0.
- R2: Channel c is stored in result register c mod 4, so channels n and n+4 share one register.
- R3: The bus address map is as follows. Address 2k reads the upper byte of result k (k = 0..3). Address 2k+1 reads the holding latch. Address 8 is the control/status byte. Every other address reads 0x00.
- R4: An upper-byte read copies that register's lower byte into the holding latch at the end of the cycle. A later lower-byte read returns the latch, even if a new conversion has rewritten the register in between.
- R5: The control/status byte has this layout: bit 7 done flag, bit 6 interrupt enable, bit 5 start, bit 4 scan, bit 3 clock select, bits 2:0 channel. A write loads bits 6:0, and a read returns all eight bits.
- R6: Writing 1 to bit 7 leaves the flag unchanged. Writing 0 leaves the flag set if the flag has not been read as 1 since it was last set.
- R7: Writing 0 to bit 7 after the flag has been read as 1 clears the flag.
- R8: A result strobe sets the flag. If the strobe coincides with a clearing write, the flag stays set.
- R9: The interrupt output is high exactly when both the flag and the interrupt enable are 1.
- R10: With scan at 0, a result strobe clears the start bit. With scan at 1, the start bit is kept.
- R11: After reset, or after any cycle with the low-power stop input high, every result register, the latch and the control/status byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lp_stop | input | 1 | Low-power/module-stop; clears all state while high |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read access in this cycle |
| bus_wr | input | 1 | Write access in this cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, same cycle |
| res_valid | input | 1 | One-cycle conversion-done strobe |
| res_chan | input | 3 | Channel of the strobed result |
| res_data | input | RES_W | Strobed conversion value |
| irq | output | 1 | Conversion-done interrupt |
| ctl_start | output | 1 | Start bit to the converter |
| ctl_scan | output | 1 | Scan-mode bit |
| ctl_clk_sel | output | 1 | Conversion clock select |
| ctl_chan | output | 3 | Selected channel |

## Verification
Two events can fall in the same cycle. The first pair is a flag-clearing bus write and a result strobe. The bench drives a write of 0x40 in the very cycle of a strobe, after arming the flag with a read. It then expects the flag still set on the next read. The second pair is a result update between the two halves of a read. The bench reads an upper byte and then strobes a new value into that register. It expects the lower-byte read to return the older half, and afterwards it expects fresh reads to return the new value.

// File: rtl/adc_regbank_pkg.sv
// Package: shared types for the converter register bank.
// Assumes the control/status byte is exactly one bus byte wide.
package adc_regbank_pkg;

    localparam int BYTE_W = 8;
    localparam int CHAN_W = 3;

    // Control/status byte, bit 7 down to bit 0.
    typedef struct packed {
        logic             done;
        logic             irq_en;
        logic             start;
        logic             scan;
        logic             clk_sel;
        logic [CHAN_W-1:0] chan;
    } csr_t;

endpackage

// File: rtl/adc_result_file.sv
// Module: result storage and holding latch.
// Stores left-justified results, one register per channel pair, and
// snapshots the lower byte when the upper byte is read.
// Assumes RES_W <= 2*BYTE_W and that write and capture may coincide.
module adc_result_file
    import adc_regbank_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int NUM_RES = 4,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              res_we,
    input  logic [IDX_W-1:0]  res_widx,
    input  logic [RES_W-1:0]  res_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic              hi_capture,
    output logic [BYTE_W-1:0] hi_byte,
    output logic [BYTE_W-1:0] temp_byte
);

    localparam int REG_W = 2 * BYTE_W;
    localparam int PAD_W = REG_W - RES_W;

    logic [REG_W-1:0]  res_q [NUM_RES];
    logic [BYTE_W-1:0] temp_q;

    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        // Load a left-justified result into register g on its strobe.
        always_ff @(posedge clk) begin
            if (clear) begin
                res_q[g] <= '0;
            end else if (res_we && (res_widx == IDX_W'(g))) begin
                res_q[g] <= {res_wdata, {PAD_W{1'b0}}};
            end
        end

        assert_store_R1: assert property (@(posedge clk) disable iff (clear)
            (res_we && (res_widx == IDX_W'(g))) |=>
                (res_q[g] == {$past(res_wdata), {PAD_W{1'b0}}}));
    end

    // Snapshot the lower byte of the register whose upper byte is read.
    always_ff @(posedge clk) begin
        if (clear) begin
            temp_q <= '0;
        end else if (hi_capture) begin
            temp_q <= res_q[rd_idx][BYTE_W-1:0];
        end
    end

    // Present the selected upper byte and the latch to the read mux.
    always_comb begin
        hi_byte   = res_q[rd_idx][REG_W-1:BYTE_W];
        temp_byte = temp_q;
    end

    assert_latch_R4: assert property (@(posedge clk) disable iff (clear)
        hi_capture |=> (temp_q == $past(res_q[rd_idx][BYTE_W-1:0])));

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (clear)
        !hi_capture |=> $stable(temp_q));

endmodule

// File: rtl/adc_ctrl_status.sv
// Module: control/status byte with a guarded done flag.
// The flag is set by a result strobe and cleared by a write of 0 only
// after it has been read as 1. Bus writes to bits 6:0 take priority over
// the self-clear of the start bit. Assumes one bus access per cycle.
module adc_ctrl_status
    import adc_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              clear,
    input  logic              csr_wr,
    input  logic              csr_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              conv_done,
    output csr_t              csr_q,
    output logic              irq
);

    csr_t wr_view;
    logic armed_q;
    logic clr_req;

    // View the write data as the register layout; detect a flag-clear write.
    always_comb begin
        wr_view = csr_t'(wdata);
        clr_req = csr_wr && !wr_view.done && armed_q;
    end

    // Done flag: strobe sets it; an armed clearing write resets it.
    always_ff @(posedge clk) begin
        if (clear) begin
            csr_q.done <= 1'b0;
        end else if (conv_done) begin
            csr_q.done <= 1'b1;
        end else if (clr_req) begin
            csr_q.done <= 1'b0;
        end
    end

    // Arm bit: records that the set flag has been read as 1.
    always_ff @(posedge clk) begin
        if (clear) begin
            armed_q <= 1'b0;
        end else if (clr_req && !conv_done) begin
            armed_q <= 1'b0;
        end else if (csr_rd && csr_q.done) begin
            armed_q <= 1'b1;
        end
    end

    // Plain read/write fields other than start.
    always_ff @(posedge clk) begin
        if (clear) begin
            csr_q.irq_en  <= 1'b0;
            csr_q.scan    <= 1'b0;
            csr_q.clk_sel <= 1'b0;
            csr_q.chan    <= '0;
        end else if (csr_wr) begin
            csr_q.irq_en  <= wr_view.irq_en;
            csr_q.scan    <= wr_view.scan;
            csr_q.clk_sel <= wr_view.clk_sel;
            csr_q.chan    <= wr_view.chan;
        end
    end

    // Start bit: written by software, self-cleared on a single-mode result.
    always_ff @(posedge clk) begin
        if (clear) begin
            csr_q.start <= 1'b0;
        end else if (csr_wr) begin
            csr_q.start <= wr_view.start;
        end else if (conv_done && !csr_q.scan) begin
            csr_q.start <= 1'b0;
        end
    end

    // Interrupt request from flag and enable.
    always_comb begin
        irq = csr_q.done && csr_q.irq_en;
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (clear)
        conv_done |=> csr_q.done);

    assert_flag_guard_R6: assert property (@(posedge clk) disable iff (clear)
        (csr_q.done && csr_wr && !armed_q && !conv_done) |=> csr_q.done);

    assert_start_single_R10: assert property (@(posedge clk) disable iff (clear)
        (conv_done && csr_q.start && !csr_q.scan && !csr_wr) |=> !csr_q.start);

    assert_start_scan_R10: assert property (@(posedge clk) disable iff (clear)
        (conv_done && csr_q.start && csr_q.scan && !csr_wr) |=> csr_q.start);

endmodule

// File: rtl/adc_bus_decode.sv
// Module: address decode and read-data mux for the 8-bit bus.
// Even addresses below the result span read upper bytes, odd ones read
// the holding latch; one address holds the control/status byte.
// Assumes read data is taken in the same cycle as the address.
module adc_bus_decode
    import adc_regbank_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_RES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] temp_byte,
    input  csr_t              csr_q,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              hi_capture,
    output logic              csr_rd,
    output logic              csr_wr,
    output logic [BYTE_W-1:0] bus_rdata
);

    localparam logic [ADDR_W-1:0] RES_SPAN = ADDR_W'(2 * NUM_RES);
    localparam logic [ADDR_W-1:0] CSR_ADDR = RES_SPAN;

    logic in_res;
    logic is_lo;
    logic is_csr;

    // Classify the address and derive access strobes.
    always_comb begin
        in_res     = bus_addr < RES_SPAN;
        is_lo      = bus_addr[0];
        is_csr     = bus_addr == CSR_ADDR;
        rd_idx     = bus_addr[IDX_W:1];
        hi_capture = bus_rd && in_res && !is_lo;
        csr_rd     = bus_rd && is_csr;
        csr_wr     = bus_wr && is_csr;
    end

    // Select the byte presented on the read data bus.
    always_comb begin
        if (in_res && !is_lo) begin
            bus_rdata = hi_byte;
        end else if (in_res) begin
            bus_rdata = temp_byte;
        end else if (is_csr) begin
            bus_rdata = csr_q;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/adc_regbank.sv
// Module: top of the converter register bank.
// Joins bus decode, result storage and control/status. Reset is
// synchronous active-low; lp_stop clears the same state while high.
module adc_regbank
    import adc_regbank_pkg::*;
#(
    parameter int RES_W   = 10,
    parameter int NUM_RES = 4,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_stop,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              res_valid,
    input  logic [2:0]        res_chan,
    input  logic [RES_W-1:0]  res_data,
    output logic              irq,
    output logic              ctl_start,
    output logic              ctl_scan,
    output logic              ctl_clk_sel,
    output logic [2:0]        ctl_chan
);

    localparam int IDX_W = $clog2(NUM_RES);

    logic              clear;
    logic [IDX_W-1:0]  rd_idx;
    logic              hi_capture;
    logic              csr_rd;
    logic              csr_wr;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] temp_byte;
    csr_t              csr_q;

    // Combined synchronous clear from reset and low-power stop.
    always_comb begin
        clear = !rst_n || lp_stop;
    end

    adc_bus_decode #(.ADDR_W(ADDR_W), .NUM_RES(NUM_RES), .IDX_W(IDX_W)) u_dec (
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .hi_byte   (hi_byte),
        .temp_byte (temp_byte),
        .csr_q     (csr_q),
        .rd_idx    (rd_idx),
        .hi_capture(hi_capture),
        .csr_rd    (csr_rd),
        .csr_wr    (csr_wr),
        .bus_rdata (bus_rdata)
    );

    adc_result_file #(.RES_W(RES_W), .NUM_RES(NUM_RES), .IDX_W(IDX_W)) u_res (
        .clk       (clk),
        .clear     (clear),
        .res_we    (res_valid),
        .res_widx  (res_chan[IDX_W-1:0]),
        .res_wdata (res_data),
        .rd_idx    (rd_idx),
        .hi_capture(hi_capture),
        .hi_byte   (hi_byte),
        .temp_byte (temp_byte)
    );

    adc_ctrl_status u_csr (
        .clk      (clk),
        .clear    (clear),
        .csr_wr   (csr_wr),
        .csr_rd   (csr_rd),
        .wdata    (bus_wdata),
        .conv_done(res_valid),
        .csr_q    (csr_q),
        .irq      (irq)
    );

    // Drive converter controls from the register fields.
    always_comb begin
        ctl_start   = csr_q.start;
        ctl_scan    = csr_q.scan;
        ctl_clk_sel = csr_q.clk_sel;
        ctl_chan    = csr_q.chan;
    end

    assert_lp_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lp_stop |=> (csr_q == '0 && !irq && temp_byte == '0));

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (clear)
        irq |-> (csr_q.done && csr_q.irq_en));

endmodule

// File: tb/sim_adc_regbank.sv
// Scoreboard bench: driver tasks push expectations, a monitor compares.
module sim_adc_regbank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lp_stop = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       res_valid = 1'b0;
    logic [2:0] res_chan = '0;
    logic [9:0] res_data = '0;
    logic       irq;
    logic       ctl_start;
    logic       ctl_scan;
    logic       ctl_clk_sel;
    logic [2:0] ctl_chan;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int         kind_q[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];

    adc_regbank u0 (
        .clk(clk), .rst_n(rst_n), .lp_stop(lp_stop),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data),
        .irq(irq), .ctl_start(ctl_start), .ctl_scan(ctl_scan),
        .ctl_clk_sel(ctl_clk_sel), .ctl_chan(ctl_chan)
    );

    always #5 clk = ~clk;

    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic v,
                       input logic [2:0] ch, input logic [9:0] val);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        res_valid = v; res_chan = ch; res_data = val; lp_stop = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 3'd0, 10'd0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0, 3'd0, 10'd0);
    endtask

    task automatic conv(input logic [2:0] ch, input logic [9:0] val);
        cyc(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, ch, val);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] e, input string tag);
        cyc(1'b0, 1'b1, a, 8'h00, 1'b0, 3'd0, 10'd0);
        kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(tag);
    endtask

    task automatic irq_chk(input logic e, input string tag);
        idle();
        kind_q.push_back(1); exp_q.push_back({7'd0, e}); tag_q.push_back(tag);
    endtask

    // Monitor: compare the pending expectation just before the next edge.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (kind_q.size() > 0) begin
                int         k;
                logic [7:0] e;
                logic [7:0] act;
                string      t;
                k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                act = (k == 0) ? bus_rdata : {7'd0, irq};
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R11: reset values
        rd_chk(4'd0, 8'h00, "R11 reset result");
        rd_chk(4'd8, 8'h00, "R11 reset csr");
        irq_chk(1'b0, "R11 reset irq");
        // R1: 0x2D7 on channel 1 -> B = B5 / C0
        conv(3'd1, 10'h2D7);
        rd_chk(4'd2, 8'hB5, "R1 upper byte");
        rd_chk(4'd3, 8'hC0, "R1 lower bits 7:6, 5:0 zero");
        // R2: channel 5 shares register B
        conv(3'd5, 10'h001);
        rd_chk(4'd2, 8'h00, "R2 ch5 upper");
        rd_chk(4'd3, 8'h40, "R2 ch5 lower");
        // R3: A and D placement, unused address
        conv(3'd0, 10'h155);
        conv(3'd7, 10'h2AA);
        rd_chk(4'd0, 8'h55, "R3 A upper");
        rd_chk(4'd1, 8'h40, "R3 A lower");
        rd_chk(4'd6, 8'hAA, "R3 D upper");
        rd_chk(4'd7, 8'h80, "R3 D lower");
        rd_chk(4'd9, 8'h00, "R3 unused address");
        // R4: lower half survives an update between the reads
        conv(3'd2, 10'h3FF);
        rd_chk(4'd4, 8'hFF, "R4 C upper");
        conv(3'd6, 10'h000);
        rd_chk(4'd5, 8'hC0, "R4 latched lower");
        rd_chk(4'd4, 8'h00, "R4 new upper");
        rd_chk(4'd5, 8'h00, "R4 new lower");
        // R6 / R7: guarded flag clear
        wr(4'd8, 8'h00);
        rd_chk(4'd8, 8'h80, "R6 unarmed clear ignored");
        wr(4'd8, 8'h80);
        rd_chk(4'd8, 8'h80, "R6 write one ignored");
        wr(4'd8, 8'h00);
        rd_chk(4'd8, 8'h00, "R7 armed clear");
        // R5: fields 6:0 read/write
        wr(4'd8, 8'h5A);
        rd_chk(4'd8, 8'h5A, "R5 field readback");
        wr(4'd8, 8'h00);
        // R9: interrupt gating
        wr(4'd8, 8'h40);
        irq_chk(1'b0, "R9 enable without flag");
        conv(3'd3, 10'h100);
        irq_chk(1'b1, "R9 flag and enable");
        rd_chk(4'd8, 8'hC0, "R9 csr after result");
        wr(4'd8, 8'h40);
        irq_chk(1'b0, "R9 after clear");
        // R8: strobe in the same cycle as a clearing write
        conv(3'd3, 10'h101);
        rd_chk(4'd8, 8'hC0, "R8 flag set");
        cyc(1'b1, 1'b0, 4'd8, 8'h40, 1'b1, 3'd3, 10'h102);
        rd_chk(4'd8, 8'hC0, "R8 collision keeps flag");
        wr(4'd8, 8'h40);
        rd_chk(4'd8, 8'h40, "R8 later clear");
        // R10: start self-clear in single mode, kept in scan
        wr(4'd8, 8'h23);
        rd_chk(4'd8, 8'h23, "R10 start set");
        conv(3'd3, 10'h010);
        rd_chk(4'd8, 8'h83, "R10 single clears start");
        wr(4'd8, 8'h33);
        rd_chk(4'd8, 8'h33, "R10 scan armed clear");
        conv(3'd3, 10'h020);
        rd_chk(4'd8, 8'hB3, "R10 scan keeps start");
        // R11: low-power stop clears everything
        rd_chk(4'd6, 8'h08, "R11 D before stop");
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; res_valid = 1'b0; lp_stop = 1'b1;
        rd_chk(4'd8, 8'h00, "R11 stop csr");
        rd_chk(4'd7, 8'h00, "R11 stop latch");
        rd_chk(4'd6, 8'h00, "R11 stop result");
        irq_chk(1'b0, "R11 stop irq");
        idle();
        idle();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule